// File: doc/BRIEF.md
# PLL Lock Interrupt and Clock-Select Controller

This block holds the control and status logic that sits beside a phase-locked loop in a clock generator. Software reaches it through a small byte-wide control register. The register holds an interrupt enable, a lock-change flag, a PLL power bit and an output-clock select bit. A separate auto-mode input comes from elsewhere in the clock generator. A lock indicator from the analog loop is synchronized inside the block. Each change of that indicator, whether the loop gains lock or loses it, raises the flag. The enable bit then decides whether the flag reaches the CPU as an interrupt request.

The block also picks the source of the main clock output. It is either the crystal clock or the VCO clock divided by two, and there is no check that the loop is locked before the VCO source is used. In stop mode it gates the oscillator, the PLL enable and its clock and interrupt outputs; an option input lets the oscillator keep running through stop. While a debug break is in progress the flag is protected from being cleared, unless a break-clear enable input allows it.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, irq_o is low and pll_en_o is low.
- R2: With auto_en_i high, every change of lock_i, rising or falling, sets the flag (register bit 6). The flag is visible at the third rising clk_i edge after the change.
- R3: The flag sets whatever the interrupt enable (bit 7) holds. irq_o is high exactly when the flag and the enable are both set, outside default stop.
- R4: With auto_en_i low, bit 6 reads 0, irq_o is low, lock changes set nothing, and the stored flag is cleared.
- R5: Outside break, a read strobe returns the flag value from before the clear in bit 6, and the flag is 0 from the next clock edge.
- R6: A lock change detected in the same cycle as a clearing read leaves the flag set.
- R7: Bit 4 clear routes xtal_clk_i to clk_out_o. Bit 4 set routes the VCO clock divided by two to clk_out_o, even while lock_i is low.
- R8: Stop with osc_in_stop_i low holds xclk_o, clk_out_o, irq_o, osc_en_o and pll_en_o low.
- R9: Stop with osc_in_stop_i high holds pll_en_o low and keeps osc_en_o high, with xclk_o and clk_out_o following xtal_clk_i.
- R10: In break with brk_clr_en_i low, neither reads nor writes of the register change the flag.
- R11: In break with brk_clr_en_i high, a read clears the flag, and it stays clear after break ends.
- R12: The register layout is bit 7 enable, bit 6 flag (read-only, writes ignored), bit 5 PLL on, bit 4 clock select, bits 3:0 reading 0. pll_en_o follows bit 5 outside stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe (clears flag) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| auto_en_i | input | 1 | Auto mode enable |
| lock_i | input | 1 | Asynchronous lock status from the PLL |
| brk_i | input | 1 | Debug break state active |
| brk_clr_en_i | input | 1 | Allow flag clearing during break |
| stop_i | input | 1 | Stop mode active |
| osc_in_stop_i | input | 1 | Keep oscillator running in stop |
| xtal_clk_i | input | 1 | Crystal oscillator clock |
| vco_clk_i | input | 1 | VCO clock |
| irq_o | output | 1 | Interrupt request to the CPU |
| pll_en_o | output | 1 | PLL power enable |
| osc_en_o | output | 1 | Oscillator enable |
| xclk_o | output | 1 | Gated crystal clock output |
| clk_out_o | output | 1 | Selected main clock output |

## Verification
The bench builds the block with its default two-stage lock synchronizer and byte-wide register. With two stages the flag-set latency is a fixed three edges, so the bench can place a clearing read exactly in the cycle where a lock change is detected. The small register lets the bench sweep every combination of auto mode, interrupt enable and lock direction, together with both stop options and both break-clear settings. Clock routing is compared against crystal and VCO stimuli whose edges fall between bench sample points, and the divide-by-two output is compared against a count kept in the bench.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int IE_BIT   = 7;
  localparam int FLAG_BIT = 6;
  localparam int ON_BIT   = 5;
  localparam int SEL_BIT  = 4;
  localparam int LOW_W    = SEL_BIT;
endpackage

// File: rtl/lock_edge_det.sv
module lock_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic lock_chg_o
);
  localparam int SR_W = SYNC_STAGES + 1;
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[SR_W-2:0], lock_i};
  end

  // synchronized value vs. its previous sample
  assign lock_chg_o = sr_q[SR_W-1] ^ sr_q[SR_W-2];
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             auto_i,
  input  logic             brk_i,
  input  logic             brk_clr_en_i,
  input  logic             lock_chg_i,
  output logic             irq_en_o,
  output logic             pll_on_o,
  output logic             clk_sel_o,
  output logic             flag_o,
  output logic [REG_W-1:0] rdata_o
);
  logic ie_q, on_q, sel_q, flag_q;
  logic clr_ok;
  logic unused_wbits;

  assign clr_ok       = rd_i & (~brk_i | brk_clr_en_i);
  assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[LOW_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      on_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_i) begin
      ie_q  <= wdata_i[IE_BIT];
      on_q  <= wdata_i[ON_BIT];
      sel_q <= wdata_i[SEL_BIT];
    end
  end

  // set beats clear; auto off forces clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (!auto_i)    flag_q <= 1'b0;
    else if (lock_chg_i) flag_q <= 1'b1;
    else if (clr_ok)     flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[IE_BIT]   = ie_q;
    rdata_o[FLAG_BIT] = flag_q & auto_i;
    rdata_o[ON_BIT]   = on_q;
    rdata_o[SEL_BIT]  = sel_q;
  end

  assign irq_en_o  = ie_q;
  assign pll_on_o  = on_q;
  assign clk_sel_o = sel_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic rst_ni,
  input  logic xtal_clk_i,
  input  logic vco_clk_i,
  input  logic sel_vco_i,
  input  logic stop_i,
  input  logic osc_in_stop_i,
  output logic osc_en_o,
  output logic xclk_o,
  output logic clk_out_o
);
  logic vco_half_q;
  logic osc_run;

  always_ff @(posedge vco_clk_i or negedge rst_ni) begin
    if (!rst_ni) vco_half_q <= 1'b0;
    else         vco_half_q <= ~vco_half_q;
  end

  assign osc_run  = ~stop_i | osc_in_stop_i;
  assign osc_en_o = osc_run;
  assign xclk_o   = xtal_clk_i & osc_run;
  // PLL is off in stop, so only the crystal may drive the output
  assign clk_out_o = stop_i ? xclk_o : (sel_vco_i ? vco_half_q : xtal_clk_i);
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             auto_en_i,
  input  logic             lock_i,
  input  logic             brk_i,
  input  logic             brk_clr_en_i,
  input  logic             stop_i,
  input  logic             osc_in_stop_i,
  input  logic             xtal_clk_i,
  input  logic             vco_clk_i,
  output logic             irq_o,
  output logic             pll_en_o,
  output logic             osc_en_o,
  output logic             xclk_o,
  output logic             clk_out_o
);
  logic lock_chg;
  logic flag;
  logic irq_en, pll_on, clk_sel;
  logic hard_stop;

  lock_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (lock_i),
    .lock_chg_o (lock_chg)
  );

  pll_ctrl_reg u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .rd_i         (reg_rd_i),
    .wdata_i      (reg_wdata_i),
    .auto_i       (auto_en_i),
    .brk_i        (brk_i),
    .brk_clr_en_i (brk_clr_en_i),
    .lock_chg_i   (lock_chg),
    .irq_en_o     (irq_en),
    .pll_on_o     (pll_on),
    .clk_sel_o    (clk_sel),
    .flag_o       (flag),
    .rdata_o      (reg_rdata_o)
  );

  clk_src_sel u_sel (
    .rst_ni        (rst_ni),
    .xtal_clk_i    (xtal_clk_i),
    .vco_clk_i     (vco_clk_i),
    .sel_vco_i     (clk_sel),
    .stop_i        (stop_i),
    .osc_in_stop_i (osc_in_stop_i),
    .osc_en_o      (osc_en_o),
    .xclk_o        (xclk_o),
    .clk_out_o     (clk_out_o)
  );

  assign hard_stop = stop_i & ~osc_in_stop_i;
  assign irq_o     = flag & irq_en & auto_en_i & ~hard_stop;
  assign pll_en_o  = pll_on & ~stop_i;
endmodule

// File: rtl/pll_lock_ctrl_chk.sv
module pll_lock_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_rd_i,
  input logic [7:0] reg_rdata_o,
  input logic       auto_en_i,
  input logic       brk_i,
  input logic       brk_clr_en_i,
  input logic       stop_i,
  input logic       osc_in_stop_i,
  input logic       irq_o,
  input logic       pll_en_o,
  input logic       xclk_o,
  input logic       clk_out_o,
  input logic       lock_chg,
  input logic       flag
);
  assert_lock_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_chg && auto_en_i) |=> flag);

  assert_auto_off_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (!irq_o && !reg_rdata_o[6]));

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !brk_i && !lock_chg) |=> !flag);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && lock_chg && auto_en_i) |=> flag);

  assert_stop_gates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !osc_in_stop_i) |-> (!xclk_o && !clk_out_o && !irq_o && !pll_en_o));

  assert_brk_protect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !brk_clr_en_i && auto_en_i && flag) |=> flag);
endmodule

bind pll_lock_ctrl pll_lock_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_rd_i      (reg_rd_i),
  .reg_rdata_o   (reg_rdata_o),
  .auto_en_i     (auto_en_i),
  .brk_i         (brk_i),
  .brk_clr_en_i  (brk_clr_en_i),
  .stop_i        (stop_i),
  .osc_in_stop_i (osc_in_stop_i),
  .irq_o         (irq_o),
  .pll_en_o      (pll_en_o),
  .xclk_o        (xclk_o),
  .clk_out_o     (clk_out_o),
  .lock_chg      (lock_chg),
  .flag          (flag)
);

// File: tb/pll_lock_ctrl_test.sv
`timescale 1ns/1ps
module pll_lock_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic auto_en = 1'b0, lock = 1'b0, brk = 1'b0, brk_clr = 1'b0;
  logic stop = 1'b0, osc_stop = 1'b0;
  logic xtal = 1'b0, vco = 1'b0;
  logic irq, pll_en, osc_en, xclk, clk_out;
  logic vco_model = 1'b0;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;
  initial begin #1; forever #8 xtal = ~xtal; end   // odd edge times
  initial begin #3; forever #6 vco  = ~vco;  end   // odd edge times

  always @(posedge vco or negedge rst_n)
    if (!rst_n) vco_model <= 1'b0; else vco_model <= ~vco_model;

  pll_lock_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .auto_en_i(auto_en),
    .lock_i(lock), .brk_i(brk), .brk_clr_en_i(brk_clr), .stop_i(stop),
    .osc_in_stop_i(osc_stop), .xtal_clk_i(xtal), .vco_clk_i(vco),
    .irq_o(irq), .pll_en_o(pll_en), .osc_en_o(osc_en), .xclk_o(xclk),
    .clk_out_o(clk_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(output logic [7:0] d);
    @(negedge clk); rd = 1'b1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic toggle_lock();
    @(negedge clk); lock = ~lock;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 pll_en", {7'd0, pll_en}, 8'd0);
    rst_n = 1'b1;

    // sweep auto x enable, lock direction alternates
    for (int a = 0; a < 2; a++) begin
      for (int e = 0; e < 2; e++) begin
        reg_wr(e ? 8'h80 : 8'h00);
        auto_en = a[0];
        reg_rd(rv);
        toggle_lock();
        chk(a ? "R2 flag set on change" : "R4 flag held 0", {7'd0, rdata[6]}, {7'd0, a[0]});
        chk(a ? "R3 irq gated by enable" : "R4 irq low", {7'd0, irq}, {7'd0, a[0] & e[0]});
      end
    end

    // read returns old value then clears (enable=1, auto=1, flag=1)
    reg_rd(rv);
    chk("R5 read old value", {7'd0, rv[6]}, 8'd1);
    chk("R5 cleared after read", {7'd0, rdata[6]}, 8'd0);
    chk("R5 irq drops", {7'd0, irq}, 8'd0);

    // set wins over clear in the same cycle
    @(negedge clk); lock = ~lock;
    @(negedge clk);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R6 set priority", {7'd0, rdata[6]}, 8'd1);

    // auto off clears stored flag
    @(negedge clk); auto_en = 1'b0;
    @(negedge clk);
    chk("R4 reads 0", {7'd0, rdata[6]}, 8'd0);
    auto_en = 1'b1;
    @(negedge clk);
    chk("R4 flag cleared", {7'd0, rdata[6]}, 8'd0);

    // register layout
    reg_wr(8'hFF);
    chk("R12 layout all ones", rdata, 8'hB0);
    chk("R12 pll_en follows", {7'd0, pll_en}, 8'd1);
    reg_wr(8'h00);
    chk("R12 layout zeros", rdata, 8'h00);

    // clock routing
    repeat (6) begin #4; chk("R7 crystal route", {7'd0, clk_out}, {7'd0, xtal}); end
    if (lock) toggle_lock();
    reg_wr(8'h10);                      // select VCO, lock low
    repeat (10) begin
      @(negedge vco); chk("R7 vco div2 route", {7'd0, clk_out}, {7'd0, vco_model});
    end

    // stop, oscillator off
    reg_wr(8'hB0);
    toggle_lock();
    chk("R3 irq before stop", {7'd0, irq}, 8'd1);
    @(negedge clk); stop = 1'b1; osc_stop = 1'b0;
    repeat (5) begin
      #4;
      chk("R8 outputs low", {3'd0, xclk, clk_out, irq, osc_en, pll_en}, 8'd0);
    end
    // stop, oscillator on
    @(negedge clk); osc_stop = 1'b1;
    repeat (5) begin
      #4;
      chk("R9 xclk runs", {6'd0, xclk, clk_out}, {6'd0, xtal, xtal});
      chk("R9 enables", {6'd0, osc_en, pll_en}, 8'b10);
    end
    @(negedge clk); stop = 1'b0; osc_stop = 1'b0;

    // break protection
    @(negedge clk); brk = 1'b1; brk_clr = 1'b0;
    reg_rd(rv);
    chk("R10 read keeps flag", {7'd0, rdata[6]}, 8'd1);
    reg_wr(8'h00);
    chk("R10 write keeps flag", {7'd0, rdata[6]}, 8'd1);
    @(negedge clk); brk_clr = 1'b1;
    reg_rd(rv);
    chk("R11 cleared in break", {7'd0, rdata[6]}, 8'd0);
    @(negedge clk); brk = 1'b0; brk_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 stays cleared", {7'd0, rdata[6]}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule